// File: doc/BRIEF.md
# Character Display Controller Core

This core models the controller that sits behind the parallel command/data bus of a 20x4 character display module. A host issues one-cycle bus strokes. An instruction stroke (select low, write) is decoded by the position of its highest set bit. A data stroke (select high) reads or writes one byte of either the 80-byte display memory or the 64-byte user pattern memory. A status stroke (select low, read) returns the busy flag and the address counter.

Every accepted instruction or data access raises a busy flag for a duration set by its class: long for clear and home, short for the other instructions, and slightly longer for data accesses. The durations are counted in ticks of a divided reference clock, and while the flag is up only status reads are served. Entry-mode, display-control and function-set bits are held in a mode register and driven out as plain outputs, together with the current view shift.

A side port turns a character code and a row number into the 5-pixel row of a user pattern. It uses the 8-pattern layout for the small font and the 4-pattern layout for the tall font.

Top module: `chr_disp_ctrl`

## Requirements
- R1: An instruction is decoded by its highest set bit: bit 0 clear, bit 1 home, bit 2 entry mode, bit 3 display control, bit 4 shift, bit 5 function set, bit 6 pattern address, bit 7 display address. The code 0x00 is ignored and raises no busy flag.
- R2: Clear writes 0x20 to all 80 display bytes, sets the address counter to 0, targets display memory and zeroes the view shift. Home does the same except that it leaves memory unchanged.
- R3: The busy flag rises in the cycle after acceptance and stays high for T_LONG*DIV cycles after clear or home, T_SHORT*DIV cycles after other instructions and T_DATA*DIV cycles after a data access.
- R4: While busy, instruction writes and data accesses have no effect on memory, on the address counter or on the modes.
- R5: A status read is served even while busy, never raises busy, and in the next cycle puts {busy, address counter[6:0]} on bus_rdata.
- R6: A pattern-address code loads bits 5:0 into the counter and targets pattern memory. A display-address code loads bits 6:0 and targets display memory; values 80 to 127 have 80 subtracted.
- R7: A data write stores the byte at the counter in the targeted memory. The counter then steps by +1 if the increment bit is set, otherwise by -1, wrapping within 0..79 for display memory and 0..63 for pattern memory.
- R8: A data read puts the byte at the counter on bus_rdata in the next cycle, then steps the counter as in R7.
- R9: In the entry-mode code, bit 1 is the increment bit and bit 0 enables shift-on-write. With shift-on-write set, each display-memory write steps view_shift by +1 or -1 (following the increment bit) modulo 80. Pattern writes do not shift the view.
- R10: In the display-control code, bits 2, 1 and 0 drive disp_on, cursor_on and blink_on. In the function-set code, bits 4, 3 and 2 drive bus8, two_line and tall_font.
- R11: In the shift code, bit 3 set moves the view and clear moves the counter; bit 2 set means +1 and clear means -1. Both wrap as in R7.
- R12: With tall_font low, pattern byte {pat_code[2:0], pat_row[2:0]} is read. With it high, byte {pat_code[2:1], pat_row[3:0]} is read. pat_bits is the low 5 bits of that byte.
- R13: After reset the core is not busy, the counter is 0 with display memory targeted, all mode bits and view_shift are 0, and bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | One-cycle bus stroke |
| bus_sel | input | 1 | 1 = data, 0 = instruction/status |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_wdata | input | 8 | Instruction code or data byte |
| bus_rdata | output | 8 | Read result (status or memory byte) |
| busy | output | 1 | Execution in progress |
| disp_on | output | 1 | Display enable mode bit |
| cursor_on | output | 1 | Cursor enable mode bit |
| blink_on | output | 1 | Blink enable mode bit |
| incr_mode | output | 1 | Counter step direction (1 = up) |
| auto_shift | output | 1 | Shift view on display write |
| bus8 | output | 1 | 8-bit bus mode bit |
| two_line | output | 1 | Two-line mode bit |
| tall_font | output | 1 | 5x10 font mode bit |
| view_shift | output | 7 | Current view offset, 0..79 |
| pat_code | input | 8 | Character code for pattern lookup |
| pat_row | input | 4 | Row within the pattern |
| pat_bits | output | 5 | Pattern row pixels |

## Verification
A wrong address counter shows at the next status read as a wrong low seven bits, and at the next data read as a byte from the wrong cell. A broken wrap appears after a single access at address 0, 79 or 63. A wrong busy count shows as an early or late fall of the busy pin, measured to the cycle. An accidental acceptance during busy leaves a changed counter or mode pin once the flag drops. A fill that stops short or overruns shows only when a cleared cell is read back, so cells at both ends of display memory are read after a clear.

// File: rtl/cdc_pkg.sv
package cdc_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_CLEAR,
    OP_HOME,
    OP_ENTRY,
    OP_DISP,
    OP_SHIFT,
    OP_FUNC,
    OP_CGADDR,
    OP_DDADDR
  } op_e;

  typedef enum logic [1:0] {
    BC_SHORT,
    BC_LONG,
    BC_DATA
  } busy_cls_e;

  typedef struct packed {
    logic incr;
    logic autosh;
    logic disp;
    logic cur;
    logic blink;
    logic bus8;
    logic two;
    logic tall;
  } mode_t;

endpackage

// File: rtl/cdc_decode.sv
module cdc_decode
  import cdc_pkg::*;
(
  input  logic [7:0] code,
  output op_e        op,
  output busy_cls_e  cls
);

  always_comb begin
    if      (code[7]) op = OP_DDADDR;
    else if (code[6]) op = OP_CGADDR;
    else if (code[5]) op = OP_FUNC;
    else if (code[4]) op = OP_SHIFT;
    else if (code[3]) op = OP_DISP;
    else if (code[2]) op = OP_ENTRY;
    else if (code[1]) op = OP_HOME;
    else if (code[0]) op = OP_CLEAR;
    else              op = OP_NONE;
  end

  always_comb begin
    if (op == OP_CLEAR || op == OP_HOME) cls = BC_LONG;
    else                                 cls = BC_SHORT;
  end

endmodule

// File: rtl/cdc_busy_timer.sv
module cdc_busy_timer
  import cdc_pkg::*;
#(
  parameter int DIV     = 4,
  parameter int T_LONG  = 413,
  parameter int T_SHORT = 11,
  parameter int T_DATA  = 12
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  busy_cls_e cls,
  output logic      busy
);

  localparam int TMAX0 = (T_LONG > T_SHORT) ? T_LONG : T_SHORT;
  localparam int TMAX  = (TMAX0 > T_DATA) ? TMAX0 : T_DATA;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int PW    = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre_q, pre_d;
  logic [TW-1:0] rem_q, rem_d;
  logic          busy_q, busy_d;
  logic [TW-1:0] load_val;
  logic          tick_en;

  always_comb begin
    case (cls)
      BC_LONG: load_val = TW'(T_LONG);
      BC_DATA: load_val = TW'(T_DATA);
      default: load_val = TW'(T_SHORT);
    endcase
  end

  assign tick_en = busy_q && (pre_q == PW'(DIV - 1));

  always_comb begin
    pre_d  = pre_q;
    rem_d  = rem_q;
    busy_d = busy_q;
    if (start) begin
      pre_d  = '0;
      rem_d  = load_val;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (tick_en) begin
        pre_d = '0;
        rem_d = rem_q - 1'b1;
        if (rem_q == TW'(1)) busy_d = 1'b0;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      rem_q  <= rem_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/cdc_addr_unit.sv
module cdc_addr_unit
  import cdc_pkg::*;
#(
  parameter int DD_DEPTH = 80,
  parameter int CG_DEPTH = 64,
  parameter int AW       = 7,
  parameter int CGW      = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_en,
  input  op_e           op,
  input  logic [6:0]    arg,
  input  logic          data_en,
  input  logic          data_wr,
  input  logic          incr,
  input  logic          autosh,
  output logic [AW-1:0] ac,
  output logic          on_cg,
  output logic [AW-1:0] view
);

  logic [AW-1:0] ac_q, ac_d;
  logic [AW-1:0] view_q, view_d;
  logic          cg_q, cg_d;
  logic [AW-1:0] dd_load;
  int            lim;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a,
                                         input logic up, input int depth);
    if (up) step = (int'(a) == depth - 1) ? '0 : a + 1'b1;
    else    step = (a == '0) ? AW'(depth - 1) : a - 1'b1;
  endfunction

  always_comb begin
    dd_load = AW'(arg);
    if (int'(dd_load) >= DD_DEPTH) dd_load = dd_load - AW'(DD_DEPTH);
  end

  assign lim = cg_q ? CG_DEPTH : DD_DEPTH;

  always_comb begin
    ac_d   = ac_q;
    view_d = view_q;
    cg_d   = cg_q;
    if (instr_en) begin
      case (op)
        OP_CLEAR, OP_HOME: begin
          ac_d   = '0;
          view_d = '0;
          cg_d   = 1'b0;
        end
        OP_SHIFT: begin
          if (arg[3]) view_d = step(view_q, arg[2], DD_DEPTH);
          else        ac_d   = step(ac_q, arg[2], lim);
        end
        OP_CGADDR: begin
          ac_d = AW'(arg[CGW-1:0]);
          cg_d = 1'b1;
        end
        OP_DDADDR: begin
          ac_d = dd_load;
          cg_d = 1'b0;
        end
        default: ;
      endcase
    end else if (data_en) begin
      ac_d = step(ac_q, incr, lim);
      if (data_wr && autosh && !cg_q) view_d = step(view_q, incr, DD_DEPTH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q   <= '0;
      view_q <= '0;
      cg_q   <= 1'b0;
    end else begin
      ac_q   <= ac_d;
      view_q <= view_d;
      cg_q   <= cg_d;
    end
  end

  assign ac    = ac_q;
  assign view  = view_q;
  assign on_cg = cg_q;

endmodule

// File: rtl/cdc_store.sv
module cdc_store #(
  parameter int         DD_DEPTH = 80,
  parameter int         CG_DEPTH = 64,
  parameter int         AW       = 7,
  parameter int         CGW      = 6,
  parameter logic [7:0] BLANK    = 8'h20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fill_start,
  input  logic           wr_en,
  input  logic           on_cg,
  input  logic [AW-1:0]  addr,
  input  logic [7:0]     wdata,
  input  logic [CGW-1:0] pat_addr,
  output logic [7:0]     rd_data,
  output logic [7:0]     pat_byte
);

  logic [7:0]    dd_mem [DD_DEPTH];
  logic [7:0]    cg_mem [CG_DEPTH];
  logic          fill_q, fill_d;
  logic [AW-1:0] idx_q, idx_d;
  logic          dd_we, cg_we;
  logic [AW-1:0] dd_wa;
  logic [7:0]    dd_wd;

  always_comb begin
    fill_d = fill_q;
    idx_d  = idx_q;
    if (fill_start) begin
      fill_d = 1'b1;
      idx_d  = '0;
    end else if (fill_q) begin
      if (int'(idx_q) == DD_DEPTH - 1) fill_d = 1'b0;
      else                             idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      fill_q <= fill_d;
      idx_q  <= idx_d;
    end
  end

  always_comb begin
    dd_we = fill_q || (wr_en && !on_cg);
    dd_wa = fill_q ? idx_q : addr;
    dd_wd = fill_q ? BLANK : wdata;
    cg_we = wr_en && on_cg && !fill_q;
  end

  always_ff @(posedge clk) begin
    if (dd_we) dd_mem[dd_wa] <= dd_wd;
  end

  always_ff @(posedge clk) begin
    if (cg_we) cg_mem[addr[CGW-1:0]] <= wdata;
  end

  assign rd_data  = on_cg ? cg_mem[addr[CGW-1:0]] : dd_mem[addr];
  assign pat_byte = cg_mem[pat_addr];

endmodule

// File: rtl/chr_disp_ctrl.sv
module chr_disp_ctrl
  import cdc_pkg::*;
#(
  parameter int         DIV      = 4,
  parameter int         T_LONG   = 413,
  parameter int         T_SHORT  = 11,
  parameter int         T_DATA   = 12,
  parameter int         DD_DEPTH = 80,
  parameter int         CG_DEPTH = 64,
  parameter logic [7:0] BLANK    = 8'h20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_valid,
  input  logic                          bus_sel,
  input  logic                          bus_rd,
  input  logic [7:0]                    bus_wdata,
  output logic [7:0]                    bus_rdata,
  output logic                          busy,
  output logic                          disp_on,
  output logic                          cursor_on,
  output logic                          blink_on,
  output logic                          incr_mode,
  output logic                          auto_shift,
  output logic                          bus8,
  output logic                          two_line,
  output logic                          tall_font,
  output logic [$clog2(DD_DEPTH)-1:0]   view_shift,
  input  logic [7:0]                    pat_code,
  input  logic [3:0]                    pat_row,
  output logic [4:0]                    pat_bits
);

  localparam int AW  = $clog2(DD_DEPTH);
  localparam int CGW = $clog2(CG_DEPTH);

  op_e        op;
  busy_cls_e  icls, cls;
  logic       status_rd, instr_acc, data_acc, data_wr, data_rd, start;
  logic [AW-1:0] ac_q;
  logic       on_cg;
  logic [7:0] mem_rd, pat_byte;
  logic [CGW-1:0] pat_addr;
  mode_t      mode_q, mode_d;
  logic [7:0] rdata_q, rdata_d;
  logic       unused_bits;

  cdc_decode u_dec (
    .code (bus_wdata),
    .op   (op),
    .cls  (icls)
  );

  assign status_rd = bus_valid && !bus_sel && bus_rd;
  assign instr_acc = bus_valid && !bus_sel && !bus_rd && !busy && (op != OP_NONE);
  assign data_acc  = bus_valid && bus_sel && !busy;
  assign data_wr   = data_acc && !bus_rd;
  assign data_rd   = data_acc && bus_rd;
  assign start     = instr_acc || data_acc;
  assign cls       = data_acc ? BC_DATA : icls;

  cdc_busy_timer #(
    .DIV     (DIV),
    .T_LONG  (T_LONG),
    .T_SHORT (T_SHORT),
    .T_DATA  (T_DATA)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .cls   (cls),
    .busy  (busy)
  );

  cdc_addr_unit #(
    .DD_DEPTH (DD_DEPTH),
    .CG_DEPTH (CG_DEPTH),
    .AW       (AW),
    .CGW      (CGW)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr_en (instr_acc),
    .op       (op),
    .arg      (bus_wdata[6:0]),
    .data_en  (data_acc),
    .data_wr  (data_wr),
    .incr     (mode_q.incr),
    .autosh   (mode_q.autosh),
    .ac       (ac_q),
    .on_cg    (on_cg),
    .view     (view_shift)
  );

  always_comb begin
    if (mode_q.tall) pat_addr = CGW'({pat_code[2:1], pat_row[3:0]});
    else             pat_addr = CGW'({pat_code[2:0], pat_row[2:0]});
  end

  cdc_store #(
    .DD_DEPTH (DD_DEPTH),
    .CG_DEPTH (CG_DEPTH),
    .AW       (AW),
    .CGW      (CGW),
    .BLANK    (BLANK)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_start (instr_acc && op == OP_CLEAR),
    .wr_en      (data_wr),
    .on_cg      (on_cg),
    .addr       (ac_q),
    .wdata      (bus_wdata),
    .pat_addr   (pat_addr),
    .rd_data    (mem_rd),
    .pat_byte   (pat_byte)
  );

  always_comb begin
    mode_d = mode_q;
    if (instr_acc) begin
      case (op)
        OP_ENTRY: begin
          mode_d.incr   = bus_wdata[1];
          mode_d.autosh = bus_wdata[0];
        end
        OP_DISP: begin
          mode_d.disp  = bus_wdata[2];
          mode_d.cur   = bus_wdata[1];
          mode_d.blink = bus_wdata[0];
        end
        OP_FUNC: begin
          mode_d.bus8 = bus_wdata[4];
          mode_d.two  = bus_wdata[3];
          mode_d.tall = bus_wdata[2];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (status_rd)    rdata_d = {busy, 7'(ac_q)};
    else if (data_rd) rdata_d = mem_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      rdata_q <= '0;
    end else begin
      mode_q  <= mode_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign disp_on    = mode_q.disp;
  assign cursor_on  = mode_q.cur;
  assign blink_on   = mode_q.blink;
  assign incr_mode  = mode_q.incr;
  assign auto_shift = mode_q.autosh;
  assign bus8       = mode_q.bus8;
  assign two_line   = mode_q.two;
  assign tall_font  = mode_q.tall;
  assign pat_bits   = pat_byte[4:0];
  assign unused_bits = ^{pat_code[7:3], pat_byte[7:5]};

endmodule

// File: rtl/cdc_checks.sv
module cdc_checks #(
  parameter int DD_DEPTH = 80,
  parameter int CG_DEPTH = 64,
  parameter int AW       = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_sel,
  input logic          bus_rd,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    bus_rdata,
  input logic          busy,
  input logic [AW-1:0] ac,
  input logic          on_cg,
  input logic [AW-1:0] view
);

  // R3: an accepted instruction or data access raises busy next cycle
  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !busy && (bus_sel || (!bus_rd && bus_wdata != 8'h00))) |=> busy);

  // R1: the zero code is ignored
  a_r1_zero_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !busy && !bus_sel && !bus_rd && bus_wdata == 8'h00) |=> !busy);

  // R4: nothing moves the counter or target while busy
  a_r4_busy_holds_ac: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(ac) && $stable(on_cg) && $stable(view)));

  // R5: status read returns busy and counter
  a_r5_status_value: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_sel && bus_rd) |=> (bus_rdata == {$past(busy), 7'($past(ac))}));

  // R2: home and clear zero the counter and view
  a_r2_home_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !busy && !bus_sel && !bus_rd && bus_wdata[7:2] == 6'd0 && bus_wdata[1:0] != 2'd0)
    |=> (ac == '0 && view == '0 && !on_cg));

  // R7: counter stays inside the targeted memory
  a_r7_ac_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (on_cg ? (int'(ac) < CG_DEPTH) : (int'(ac) < DD_DEPTH)));

  // R9: view offset stays inside display memory
  a_r9_view_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(view) < DD_DEPTH);

endmodule

bind chr_disp_ctrl cdc_checks #(
  .DD_DEPTH (DD_DEPTH),
  .CG_DEPTH (CG_DEPTH),
  .AW       (AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_sel   (bus_sel),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .busy      (busy),
  .ac        (ac_q),
  .on_cg     (on_cg),
  .view      (view_shift)
);

// File: tb/test_chr_disp_ctrl.sv
module test_chr_disp_ctrl;

  localparam int DIV = 4, T_LONG = 413, T_SHORT = 11, T_DATA = 12;
  localparam int NV = 23;

  logic       clk, rst_n, bus_valid, bus_sel, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       busy, disp_on, cursor_on, blink_on, incr_mode, auto_shift;
  logic       bus8, two_line, tall_font;
  logic [6:0] view_shift;
  logic [7:0] pat_code;
  logic [3:0] pat_row;
  logic [4:0] pat_bits;
  int checks, errors;

  chr_disp_ctrl #(.DIV(DIV), .T_LONG(T_LONG), .T_SHORT(T_SHORT), .T_DATA(T_DATA)) i_chr_disp_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .disp_on(disp_on),
    .cursor_on(cursor_on), .blink_on(blink_on), .incr_mode(incr_mode), .auto_shift(auto_shift),
    .bus8(bus8), .two_line(two_line), .tall_font(tall_font), .view_shift(view_shift),
    .pat_code(pat_code), .pat_row(pat_row), .pat_bits(pat_bits));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {check, sel, rd, wdata, expected}
  localparam logic [18:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 1'b0, 8'h06, 8'h00},
    {1'b0, 1'b0, 1'b0, 8'h85, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'h41, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'h42, 8'h00},
    {1'b0, 1'b0, 1'b0, 8'h85, 8'h00},
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h41},
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h42},
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h07},
    {1'b0, 1'b0, 1'b0, 8'h04, 8'h00},
    {1'b0, 1'b0, 1'b0, 8'h80, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'h55, 8'h00},
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h4F},
    {1'b0, 1'b0, 1'b0, 8'h06, 8'h00},
    {1'b0, 1'b0, 1'b0, 8'h7F, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'h1F, 8'h00},
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h00},
    {1'b0, 1'b0, 1'b0, 8'h7F, 8'h00},
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h1F},
    {1'b0, 1'b0, 1'b0, 8'hDA, 8'h00},
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h0A},
    {1'b0, 1'b0, 1'b0, 8'h80, 8'h00},
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h55},
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h01}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic sel, input logic rd, input logic [7:0] d, input logic wait_idle);
    if (wait_idle) while (busy) @(negedge clk);
    bus_valid = 1'b1; bus_sel = sel; bus_rd = rd; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_sel = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic status(output logic [7:0] s);
    op(1'b0, 1'b1, 8'h00, 1'b1);
    s = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] s;
    checks = 0; errors = 0;
    rst_n = 1'b0; bus_valid = 1'b0; bus_sel = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;
    pat_code = 8'h00; pat_row = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    check("R13 busy", busy, 0);
    check("R13 rdata", bus_rdata, 0);
    check("R13 modes", {disp_on, cursor_on, blink_on, incr_mode, auto_shift, bus8, two_line, tall_font}, 0);
    check("R13 view", view_shift, 0);
    status(s);
    check("R13 status", s, 8'h00);

    // R1 zero code ignored
    op(1'b0, 1'b0, 8'h00, 1'b1);
    check("R1 zero code busy", busy, 0);

    // table walk: R6 R7 R8 R5
    for (int i = 0; i < NV; i++) begin
      op(VEC[i][17], VEC[i][16], VEC[i][15:8], 1'b1);
      if (VEC[i][18]) check($sformatf("R6 R7 R8 R5 step %0d", i), bus_rdata, VEC[i][7:0]);
    end

    // R2 R3 clear
    op(1'b0, 1'b0, 8'h01, 1'b1);
    busy_len(n);
    check("R3 long busy", n, T_LONG * DIV);
    status(s);
    check("R2 clear ac", s, 8'h00);
    op(1'b0, 1'b0, 8'h80, 1'b1);
    op(1'b1, 1'b1, 8'h00, 1'b1);
    check("R2 clear cell 0", bus_rdata, 8'h20);
    op(1'b0, 1'b0, 8'hCF, 1'b1);
    op(1'b1, 1'b1, 8'h00, 1'b1);
    check("R2 clear cell 79", bus_rdata, 8'h20);

    // R3 short and data durations
    op(1'b0, 1'b0, 8'h85, 1'b1);
    busy_len(n);
    check("R3 short busy", n, T_SHORT * DIV);
    op(1'b1, 1'b0, 8'h33, 1'b1);
    // R4 R5 during busy
    op(1'b0, 1'b1, 8'h00, 1'b0);
    check("R5 status while busy", bus_rdata, 8'h86);
    op(1'b0, 1'b0, 8'hA0, 1'b0);
    op(1'b1, 1'b0, 8'h77, 1'b0);
    op(1'b0, 1'b0, 8'h0F, 1'b0);
    busy_len(n);
    check("R3 data busy", n, T_DATA * DIV - 4);
    status(s);
    check("R4 ac unchanged", s, 8'h06);
    check("R4 mode unchanged", disp_on, 0);
    op(1'b0, 1'b0, 8'h85, 1'b1);
    op(1'b1, 1'b1, 8'h00, 1'b1);
    check("R4 cell not overwritten", bus_rdata, 8'h33);

    // R11 shift, R2 home
    op(1'b0, 1'b0, 8'h9E, 1'b1);
    op(1'b0, 1'b0, 8'h1C, 1'b1);
    check("R11 view right", view_shift, 1);
    op(1'b0, 1'b0, 8'h18, 1'b1);
    op(1'b0, 1'b0, 8'h18, 1'b1);
    check("R11 view wrap", view_shift, 79);
    op(1'b0, 1'b0, 8'h14, 1'b1);
    status(s);
    check("R11 cursor right", s, 8'h1F);
    op(1'b0, 1'b0, 8'h02, 1'b1);
    busy_len(n);
    check("R3 home busy", n, T_LONG * DIV);
    check("R2 home view", view_shift, 0);
    status(s);
    check("R2 home ac", s, 8'h00);
    op(1'b0, 1'b0, 8'h85, 1'b1);
    op(1'b1, 1'b1, 8'h00, 1'b1);
    check("R2 home keeps ram", bus_rdata, 8'h33);

    // R9 shift on write
    op(1'b0, 1'b0, 8'h07, 1'b1);
    check("R9 mode bits", {incr_mode, auto_shift}, 2'b11);
    op(1'b1, 1'b0, 8'h61, 1'b1);
    check("R9 view stepped", view_shift, 1);
    op(1'b0, 1'b0, 8'h06, 1'b1);
    op(1'b1, 1'b0, 8'h62, 1'b1);
    check("R9 no shift when off", view_shift, 1);

    // R10 mode bits, R1 decode
    op(1'b0, 1'b0, 8'h0F, 1'b1);
    check("R10 R1 display ctrl", {disp_on, cursor_on, blink_on}, 3'b111);
    op(1'b0, 1'b0, 8'h3C, 1'b1);
    check("R10 R1 function set", {bus8, two_line, tall_font}, 3'b111);
    op(1'b0, 1'b0, 8'h20, 1'b1);
    check("R10 function clear", {bus8, two_line, tall_font}, 3'b000);

    // R12 pattern lookup
    op(1'b0, 1'b0, 8'h53, 1'b1);
    op(1'b1, 1'b0, 8'h15, 1'b1);
    op(1'b0, 1'b0, 8'h79, 1'b1);
    op(1'b1, 1'b0, 8'h2E, 1'b1);
    pat_code = 8'h0A; pat_row = 4'd3;
    #1;
    check("R12 small font", pat_bits, 5'h15);
    op(1'b0, 1'b0, 8'h24, 1'b1);
    pat_code = 8'h06; pat_row = 4'd9;
    #1;
    check("R12 tall font", pat_bits, 5'h0E);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule